// File: doc/BRIEF.md
# Flash Block Erase and Blank-Check Sequencer

This block drives the control lines of a flash array through the full erase of one block, then reads the block back to confirm it is blank. It raises the write-enable line, arms the watchdog, steps through erase setup and the long erase pulse, and releases each line in order. It then enters verify mode and walks the block one 16-bit word at a time. Each word gets a dummy write of 0xFF followed by a read.

Every change on a control line is followed by its own programmable delay, given in clock cycles. One down-counter times all of these delays. If a word does not read back as all ones, the block is erased again. Once the retry limit is used up, the sequencer releases the array and reports failure. It never writes the block to zero before erasing it.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset all outputs are low. When idle, a `start` with exactly one `blk_sel` bit set and an even `blk_start` is accepted at the next clock edge. At that edge `swe_en` and `busy` go high, `erase_blk` takes the value of `blk_sel`, and the attempt count is set to 1.
- R2: When idle, a `start` with no `blk_sel` bit set, with two or more set, or with an odd `blk_start` produces a one-cycle `rejected` pulse. No control line changes and `busy` stays low.
- R3: Each control-line change follows the previous one by exactly L+2 clock cycles, where L is that interval's wait count. A wait count of 0 gives 2 cycles.
- R4: Each erase attempt runs in this order. First `wdt_en` and `esu_en` rise together. After `w_esu_on`, `ers_en` rises and stays high for `w_erase`. `ers_en` then falls. After `w_ers_off`, `esu_en` falls. After `w_esu_off`, `wdt_en` falls and `ev_en` rises in the same cycle. `ers_en` is only high while `swe_en`, `esu_en` and `wdt_en` are high.
- R5: Verify starts at `blk_start`, `w_ev_on` after `ev_en` rises. At each address, `dummy_wr` pulses for one cycle. `rd_data` is sampled `w_read`+2 cycles later and passes only if it is 0xFFFF. After a passing word below `blk_end`, the next dummy write follows at the address plus 2, `w_read`+3 cycles after the previous one.
- R6: On a failing word, `ev_en` falls and no later address is read. If the attempt count is below the limit, it is incremented and a new attempt starts after `w_ev_off` with `wdt_en` and `esu_en` rising.
- R7: When the word at or beyond `blk_end` passes, `ev_en` falls. After `w_ev_off`, `swe_en` falls. After `w_swe_off`, `done` pulses for one cycle and `busy` falls.
- R8: On a failing word with the attempt count equal to the limit, `ev_en` falls, then `swe_en` falls after `w_ev_off`, then `fail` pulses for one cycle after `w_swe_off`. A limit of 0 behaves as a limit of 1.
- R9: `busy` is high from acceptance until `done` or `fail`. A `start` while busy is ignored.
- R10: `dummy_wr` is only ever high while `ev_en` is high. No write reaches the block before it is erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| blk_sel | input | BLK_W | One-hot block choice |
| blk_start | input | ADDR_W | First byte address of the block, even |
| blk_end | input | ADDR_W | Address of the last word of the block |
| max_tries | input | TRY_W | Erase attempt limit N |
| w_swe_on | input | CNT_W | Wait after write enable rises |
| w_esu_on | input | CNT_W | Wait after erase setup rises |
| w_erase | input | CNT_W | Erase pulse length |
| w_ers_off | input | CNT_W | Wait after erase falls |
| w_esu_off | input | CNT_W | Wait after erase setup falls |
| w_ev_on | input | CNT_W | Wait after verify mode rises |
| w_read | input | CNT_W | Wait from dummy write to read |
| w_ev_off | input | CNT_W | Wait after verify mode falls |
| w_swe_off | input | CNT_W | Wait after write enable falls |
| rd_data | input | DATA_W | Word read from the array at `vaddr` |
| swe_en | output | 1 | Software write enable |
| esu_en | output | 1 | Erase setup |
| ers_en | output | 1 | Erase |
| ev_en | output | 1 | Erase verify mode |
| wdt_en | output | 1 | Watchdog enable |
| dummy_wr | output | 1 | One-cycle dummy write of 0xFF at `vaddr` |
| vaddr | output | ADDR_W | Verify address |
| erase_blk | output | BLK_W | Latched block choice during a run |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| rejected | output | 1 | One-cycle invalid request pulse |

## Verification
The assertions assume that the wait counts, `blk_end` and `rd_data` only change as an array and a controller would make them change. In particular, the wait counts are read live and must hold steady for the whole run, and `blk_end` must be no lower than `blk_start`. The stimulus sets the wait counts only while the block is idle. It always passes an even start address together with a matching end address. Its array model answers reads as a word-indexed copy of the array, with no added latency. Requests that break the select or alignment rule are sent on purpose, to show that the block stays idle and gives only the reject pulse.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_ARM, ST_ERS_ON, ST_ERS_OFF, ST_ESU_OFF, ST_EV_ON,
    ST_DUMMY, ST_READ, ST_RETRY, ST_SWE_OFF, ST_FIN_OK, ST_FIN_BAD
  } fe_state_t;
endpackage

// File: rtl/fe_sel_check.sv
module fe_sel_check #(
  parameter int BLK_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic [BLK_W-1:0]  sel,
  input  logic [ADDR_W-1:0] first_addr,
  output logic              ok
);
  always_comb ok = $onehot(sel) && !first_addr[0];
endmodule

// File: rtl/fe_delay.sv
module fe_delay #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);
endmodule

// File: rtl/fe_addr_walk.sv
module fe_addr_walk #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              rewind,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
  logic [ADDR_W-1:0] first_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
      addr    <= '0;
    end else begin
      if (capture) begin
        first_q <= first_addr;
        last_q  <= last_addr;
      end
      if (rewind)    addr <= first_q;
      else if (step) addr <= addr + WORD_STEP;
    end
  end

  assign at_end = (addr >= last_q);

  assert_step_in_block_R5: assert property (@(posedge clk) disable iff (rst)
    step |-> !at_end);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 24,
  parameter int TRY_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BLK_W-1:0]  blk_sel,
  input  logic [ADDR_W-1:0] blk_start,
  input  logic [ADDR_W-1:0] blk_end,
  input  logic [TRY_W-1:0]  max_tries,
  input  logic [CNT_W-1:0]  w_swe_on,
  input  logic [CNT_W-1:0]  w_esu_on,
  input  logic [CNT_W-1:0]  w_erase,
  input  logic [CNT_W-1:0]  w_ers_off,
  input  logic [CNT_W-1:0]  w_esu_off,
  input  logic [CNT_W-1:0]  w_ev_on,
  input  logic [CNT_W-1:0]  w_read,
  input  logic [CNT_W-1:0]  w_ev_off,
  input  logic [CNT_W-1:0]  w_swe_off,
  input  logic [DATA_W-1:0] rd_data,
  output logic              swe_en,
  output logic              esu_en,
  output logic              ers_en,
  output logic              ev_en,
  output logic              wdt_en,
  output logic              dummy_wr,
  output logic [ADDR_W-1:0] vaddr,
  output logic [BLK_W-1:0]  erase_blk,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              rejected
);
  fe_state_t        state, nxt;
  logic [TRY_W-1:0] tries, tries_max;
  logic             sel_ok, tmr_load, tmr_zero, at_end, word_ok, again, accept;
  logic [CNT_W-1:0] tmr_val;

  fe_sel_check #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_sel (
    .sel(blk_sel), .first_addr(blk_start), .ok(sel_ok));

  fe_delay #(.CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero));

  assign word_ok = &rd_data;
  assign again   = (tries < tries_max);
  assign accept  = (state == ST_IDLE) && start && sel_ok;

  fe_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst(rst), .capture(accept), .first_addr(blk_start),
    .last_addr(blk_end), .rewind(state == ST_EV_ON),
    .step((state == ST_READ) && word_ok && !at_end),
    .addr(vaddr), .at_end(at_end));

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = '0;
    case (state)
      ST_IDLE:    begin tmr_load = accept; tmr_val = w_swe_on; end
      ST_ARM:     tmr_val = w_esu_on;
      ST_ERS_ON:  tmr_val = w_erase;
      ST_ERS_OFF: tmr_val = w_ers_off;
      ST_ESU_OFF: tmr_val = w_esu_off;
      ST_EV_ON:   tmr_val = w_ev_on;
      ST_DUMMY:   tmr_val = w_read;
      ST_READ:    begin tmr_load = !(word_ok && !at_end); tmr_val = w_ev_off; end
      ST_RETRY:   tmr_val = again ? w_esu_on : w_swe_off;
      ST_SWE_OFF: tmr_val = w_swe_off;
      default:    tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;   nxt <= ST_IDLE;
      swe_en <= 1'b0;     esu_en <= 1'b0;   ers_en <= 1'b0;
      ev_en <= 1'b0;      wdt_en <= 1'b0;   dummy_wr <= 1'b0;
      busy <= 1'b0;       done <= 1'b0;     fail <= 1'b0;
      rejected <= 1'b0;   erase_blk <= '0;
      tries <= '0;        tries_max <= '0;
    end else begin
      dummy_wr <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      rejected <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (sel_ok) begin
            swe_en <= 1'b1;  busy <= 1'b1;
            erase_blk <= blk_sel;
            tries <= TRY_W'(1);  tries_max <= max_tries;
            nxt <= ST_ARM;   state <= ST_WAIT;
          end else begin
            rejected <= 1'b1;
          end
        end
        ST_WAIT:    if (tmr_zero) state <= nxt;
        ST_ARM:     begin wdt_en <= 1'b1; esu_en <= 1'b1; nxt <= ST_ERS_ON;  state <= ST_WAIT; end
        ST_ERS_ON:  begin ers_en <= 1'b1; nxt <= ST_ERS_OFF; state <= ST_WAIT; end
        ST_ERS_OFF: begin ers_en <= 1'b0; nxt <= ST_ESU_OFF; state <= ST_WAIT; end
        ST_ESU_OFF: begin esu_en <= 1'b0; nxt <= ST_EV_ON;   state <= ST_WAIT; end
        ST_EV_ON:   begin wdt_en <= 1'b0; ev_en <= 1'b1; nxt <= ST_DUMMY; state <= ST_WAIT; end
        ST_DUMMY:   begin dummy_wr <= 1'b1; nxt <= ST_READ; state <= ST_WAIT; end
        ST_READ: begin
          if (word_ok && !at_end) begin
            state <= ST_DUMMY;
          end else begin
            ev_en <= 1'b0;
            nxt   <= word_ok ? ST_SWE_OFF : ST_RETRY;
            state <= ST_WAIT;
          end
        end
        ST_RETRY: begin
          if (again) begin
            tries  <= tries + 1'b1;
            wdt_en <= 1'b1;  esu_en <= 1'b1;
            nxt    <= ST_ERS_ON;
          end else begin
            swe_en <= 1'b0;
            nxt    <= ST_FIN_BAD;
          end
          state <= ST_WAIT;
        end
        ST_SWE_OFF: begin swe_en <= 1'b0; nxt <= ST_FIN_OK; state <= ST_WAIT; end
        ST_FIN_OK:  begin done <= 1'b1; busy <= 1'b0; erase_blk <= '0; state <= ST_IDLE; end
        ST_FIN_BAD: begin fail <= 1'b1; busy <= 1'b0; erase_blk <= '0; state <= ST_IDLE; end
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assert_ers_interlock_R4: assert property (@(posedge clk) disable iff (rst)
    ers_en |-> (swe_en && esu_en && wdt_en));
  assert_verify_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    ev_en |-> (swe_en && !esu_en && !ers_en));
  assert_dummy_in_verify_R10: assert property (@(posedge clk) disable iff (rst)
    dummy_wr |-> ev_en);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_fail_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);
  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  assert_one_block_R1: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(erase_blk) == 1));
  assert_reject_idle_R2: assert property (@(posedge clk) disable iff (rst)
    rejected |-> (!busy && !swe_en));
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int BLK_W = 8, ADDR_W = 16, DATA_W = 16, CNT_W = 24, TRY_W = 4;
  localparam int C_SWE_ON = 1, C_SWE_OFF = 2, C_WDT_ON = 3, C_WDT_OFF = 4,
                 C_ESU_ON = 5, C_ESU_OFF = 6, C_ERS_ON = 7, C_ERS_OFF = 8,
                 C_EV_ON = 9, C_EV_OFF = 10, C_DUMMY = 11, C_DONE = 12,
                 C_FAIL = 13, C_REJ = 14;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [BLK_W-1:0]  blk_sel = '0;
  logic [ADDR_W-1:0] blk_start = '0, blk_end = '0;
  logic [TRY_W-1:0]  max_tries = '0;
  logic [CNT_W-1:0]  w [9];
  logic [DATA_W-1:0] rd_data;
  logic swe_en, esu_en, ers_en, ev_en, wdt_en, dummy_wr, busy, done, fail, rejected;
  logic [ADDR_W-1:0] vaddr;
  logic [BLK_W-1:0]  erase_blk;

  int tests = 0, fails = 0, cyc = 0, last_cyc = 0;
  logic [DATA_W-1:0] mem [64];
  int stub [8];

  typedef struct { int code; int val; int dly; string req; } ev_t;
  ev_t expq [$];

  always #4 clk = ~clk;

  flash_erase_seq #(.BLK_W(BLK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                    .CNT_W(CNT_W), .TRY_W(TRY_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .blk_sel(blk_sel),
    .blk_start(blk_start), .blk_end(blk_end), .max_tries(max_tries),
    .w_swe_on(w[0]), .w_esu_on(w[1]), .w_erase(w[2]), .w_ers_off(w[3]),
    .w_esu_off(w[4]), .w_ev_on(w[5]), .w_read(w[6]), .w_ev_off(w[7]),
    .w_swe_off(w[8]), .rd_data(rd_data), .swe_en(swe_en), .esu_en(esu_en),
    .ers_en(ers_en), .ev_en(ev_en), .wdt_en(wdt_en), .dummy_wr(dummy_wr),
    .vaddr(vaddr), .erase_blk(erase_blk), .busy(busy), .done(done),
    .fail(fail), .rejected(rejected));

  // array model: 8 blocks of 8 words, word index from byte address
  assign rd_data = mem[vaddr[6:1]];

  always @(posedge ers_en) begin
    for (int b = 0; b < 8; b++) begin
      if (erase_blk[b]) begin
        for (int k = 0; k < 8; k++)
          mem[b*8+k] = (stub[b] > 0 && k == 3) ? 16'h0000 : 16'hFFFF;
        if (stub[b] > 0) stub[b]--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int code, input int val, input int dly, input string req);
    ev_t e;
    e.code = code; e.val = val; e.dly = dly; e.req = req;
    expq.push_back(e);
  endtask

  task automatic got(input int code, input int val);
    ev_t e;
    if (expq.size() == 0) begin
      check(1'b0, "R2/R9 unexpected event", code, 0);
    end else begin
      e = expq.pop_front();
      check(e.code == code, {e.req, " event code"}, code, e.code);
      check(e.val == val, {e.req, " value"}, val, e.val);
      if (e.dly >= 0) check(e.dly == cyc - last_cyc, {e.req, " delay"}, cyc - last_cyc, e.dly);
    end
    last_cyc = cyc;
  endtask

  // monitor: sample away from the active edge
  logic p_swe = 0, p_wdt = 0, p_esu = 0, p_ers = 0, p_ev = 0, p_dw = 0, p_dn = 0, p_fl = 0, p_rj = 0;
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (swe_en != p_swe) got(swe_en ? C_SWE_ON : C_SWE_OFF, 0);
      if (wdt_en != p_wdt) got(wdt_en ? C_WDT_ON : C_WDT_OFF, 0);
      if (esu_en != p_esu) got(esu_en ? C_ESU_ON : C_ESU_OFF, 0);
      if (ers_en != p_ers) got(ers_en ? C_ERS_ON : C_ERS_OFF, 0);
      if (ev_en != p_ev)   got(ev_en ? C_EV_ON : C_EV_OFF, 0);
      if (dummy_wr && !p_dw) got(C_DUMMY, int'(vaddr));
      if (done && !p_dn)     got(C_DONE, 0);
      if (fail && !p_fl)     got(C_FAIL, 0);
      if (rejected && !p_rj) got(C_REJ, 0);
    end
    p_swe = swe_en; p_wdt = wdt_en; p_esu = esu_en; p_ers = ers_en; p_ev = ev_en;
    p_dw = dummy_wr; p_dn = done; p_fl = fail; p_rj = rejected;
  end

  // driver: expected events from the requirements
  task automatic plan_run(input int b, input int ntry, input int s);
    int effn = (ntry == 0) ? 1 : ntry;
    bit ok = (s < effn);
    int att = ok ? s + 1 : effn;
    push(C_SWE_ON, 0, -1, "R1");
    for (int k = 1; k <= att; k++) begin
      int nw = (ok && k == att) ? 8 : 4;
      if (k == 1) push(C_WDT_ON, 0, int'(w[0]) + 2, "R3");
      else        push(C_WDT_ON, 0, int'(w[7]) + 2, "R6");
      push(C_ESU_ON, 0, 0, "R4");
      push(C_ERS_ON, 0, int'(w[1]) + 2, "R3");
      push(C_ERS_OFF, 0, int'(w[2]) + 2, "R3");
      push(C_ESU_OFF, 0, int'(w[3]) + 2, "R4");
      push(C_WDT_OFF, 0, int'(w[4]) + 2, "R4");
      push(C_EV_ON, 0, 0, "R4");
      for (int i = 0; i < nw; i++)
        push(C_DUMMY, b*16 + 2*i, (i == 0) ? int'(w[5]) + 2 : int'(w[6]) + 3, "R5");
      push(C_EV_OFF, 0, int'(w[6]) + 2, (ok && k == att) ? "R7" : "R6");
      if (ok && k == att) begin
        push(C_SWE_OFF, 0, int'(w[7]) + 2, "R7");
        push(C_DONE, 0, int'(w[8]) + 2, "R7");
      end else if (k == att) begin
        push(C_SWE_OFF, 0, int'(w[7]) + 2, "R8");
        push(C_FAIL, 0, int'(w[8]) + 2, "R8");
      end
    end
  endtask

  task automatic run(input int b, input int ntry, input int s, input bit poke);
    int guard = 0;
    for (int k = 0; k < 8; k++) mem[b*8+k] = 16'h0000;
    stub[b] = s;
    plan_run(b, ntry, s);
    @(negedge clk);
    start = 1'b1; blk_sel = BLK_W'(1) << b;
    blk_start = ADDR_W'(b*16); blk_end = ADDR_W'(b*16 + 14);
    max_tries = TRY_W'(ntry);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R9 busy during run", int'(busy), 1);
    check(erase_blk == (BLK_W'(1) << b), "R1 latched block", int'(erase_blk), 1 << b);
    if (poke) begin
      start = 1'b1; blk_sel = BLK_W'(1) << ((b + 1) % 8);
      blk_start = ADDR_W'(((b + 1) % 8) * 16);
      @(negedge clk);
      start = 1'b0;
    end
    while (expq.size() > 0 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    check(expq.size() == 0, "R3 all expected events seen", expq.size(), 0);
    check(busy == 1'b0, "R9 busy low at end", int'(busy), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic reject(input logic [BLK_W-1:0] sel, input logic [ADDR_W-1:0] a);
    push(C_REJ, 0, -1, "R2");
    @(negedge clk);
    start = 1'b1; blk_sel = sel; blk_start = a; blk_end = a + 14;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R2 reject pulse seen", expq.size(), 0);
    check(busy == 1'b0 && swe_en == 1'b0, "R2 stays idle", int'(busy), 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h1234;
    for (int i = 0; i < 8; i++) stub[i] = 0;
    w[0] = 3; w[1] = 2; w[2] = 20; w[3] = 1; w[4] = 2;
    w[5] = 4; w[6] = 1; w[7] = 2; w[8] = 3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({swe_en, esu_en, ers_en, ev_en, wdt_en, dummy_wr, busy, done, fail, rejected} == '0,
          "R1 reset state", 1, 0);
    run(2, 3, 0, 1'b1);   // first-try pass, start while busy (R9, R10)
    run(5, 3, 2, 1'b0);   // two re-erases then pass (R6)
    run(1, 2, 5, 1'b0);   // limit exhausted (R8)
    run(6, 0, 3, 1'b0);   // limit 0 acts as 1 (R8)
    for (int i = 0; i < 9; i++) w[i] = 0;
    run(0, 4, 1, 1'b0);   // zero waits (R3)
    reject('0, 16'h0000);
    reject(8'b0001_0100, 16'h0040);
    reject(8'b0000_1000, 16'h0031);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule